// File: doc/BRIEF.md
# Frame-Tick Interrupt and Watchdog Timers

This block turns the 8 kHz frame-sync tick into two timing outputs for a control processor. The first output is an active-low periodic interrupt. A free-running counter marks a boundary every 64 ticks (8 ms). At each boundary the interrupt goes low, and it stays low until the processor strobes a release. A boundary that arrives while the interrupt is still low is absorbed. As a result, interrupts are spaced 8 ms apart when the processor answers promptly, and 16 ms apart when it answers late. Releasing the interrupt never shifts the boundary grid.

The second output is a watchdog. If the processor does not kick it, it produces a 32-tick (4 ms) low pulse every 4000 ticks (500 ms). The first pulse comes 4000 ticks after reset is released. A kick reloads the count and cuts short any pulse that is in progress.

Both timers advance only on ticks. When the frame sync stops, both outputs hold their level. The register decode that produces the release and kick strobes sits outside this block.

Top module: `frame_tick_timers`

## Requirements
- R1: While rst_ni is low, irq_no and wdt_no are both high and both tick counts are cleared, whatever the other inputs are doing.
- R2: irq_no goes low on the clock after every 64th tick counted since reset, which is a boundary of the free-running interrupt count.
- R3: A one-cycle irq_release_i pulse drives irq_no high on the following clock, provided no boundary occurs in that same cycle.
- R4: A release does not restart the interrupt count. A boundary that occurs while irq_no is already low is absorbed, so a release within 64 ticks gives an interrupt spacing of 64 ticks, and a release between 64 and 128 ticks gives a spacing of 128 ticks.
- R5: In cycles with tick_i low, irq_no changes only on a release and wdt_no changes only on a kick.
- R6: With no kicks, wdt_no is low for exactly 32 ticks and repeats with a period of 4000 ticks.
- R7: After reset, the first wdt_no low pulse begins on the clock after the 4000th tick.
- R8: A wdt_kick_i pulse drives wdt_no high on the following clock and reloads the watchdog count. A kick has priority over a tick in the same cycle. The next pulse then begins 4000 ticks after the kick.
- R9: When a boundary and a release fall in the same cycle, the boundary wins and irq_no is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per 8 kHz frame sync |
| irq_release_i | input | 1 | One-cycle interrupt release strobe |
| wdt_kick_i | input | 1 | One-cycle watchdog restart strobe |
| irq_no | output | 1 | Active-low periodic interrupt |
| wdt_no | output | 1 | Active-low watchdog pulse |

## Verification
The bench targets a late release that straddles a boundary. A design that restarted the count on release, or that re-fired on an absorbed boundary, would produce interrupts at the wrong spacing. It also drives a release in the same cycle as a boundary; a design with the wrong priority would leave the interrupt high for a whole period. On the watchdog side, the bench measures the first-pulse delay, the pulse width and the repeat period to the exact tick, so an off-by-one compare shows up as a one-tick shift. It kicks in the middle of a pulse to catch a pulse that keeps running. Long idle stretches without ticks expose any output that moves on the clock instead of on the tick.

// File: rtl/ftt_pkg.sv
package ftt_pkg;
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  typedef enum logic {WDT_QUIET = 1'b0, WDT_ARMED = 1'b1} wdt_state_e;
endpackage

// File: rtl/ftt_tick_divider.sv
module ftt_tick_divider #(
  parameter int unsigned MOD = 64,
  localparam int unsigned CW = ftt_pkg::cnt_w(MOD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = tick_i && !clr_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ftt_irq_latch.sv
module ftt_irq_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boundary_i,
  input  logic release_i,
  output logic irq_no
);
  logic pend_q;

  // boundary outranks release in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (boundary_i) pend_q <= 1'b1;
    else if (release_i)  pend_q <= 1'b0;
  end

  assign irq_no = !pend_q;
endmodule

// File: rtl/ftt_wdt.sv
module ftt_wdt #(
  parameter int unsigned PERIOD = 4000,
  parameter int unsigned LOW_W  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic kick_i,
  output logic wrap_o,
  output logic wdt_no
);
  import ftt_pkg::*;
  localparam int unsigned CW = cnt_w(PERIOD);
  localparam logic [CW-1:0] LOW_LIM = CW'(LOW_W);

  logic [CW-1:0] cnt;
  wdt_state_e    st_q;

  ftt_tick_divider #(.MOD(PERIOD)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .clr_i (kick_i),
    .cnt_o (cnt),
    .wrap_o(wrap_o)
  );

  // armed after first full period; a kick disarms and reloads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= WDT_QUIET;
    else if (kick_i) st_q <= WDT_QUIET;
    else if (wrap_o) st_q <= WDT_ARMED;
  end

  assign wdt_no = !((st_q == WDT_ARMED) && (cnt < LOW_LIM));
endmodule

// File: rtl/frame_tick_timers.sv
module frame_tick_timers #(
  parameter int unsigned IRQ_TICKS = 64,
  parameter int unsigned WDT_TICKS = 4000,
  parameter int unsigned WDT_LOW   = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic irq_release_i,
  input  logic wdt_kick_i,
  output logic irq_no,
  output logic wdt_no
);
  localparam int unsigned ICW = ftt_pkg::cnt_w(IRQ_TICKS);

  logic [ICW-1:0] irq_cnt;
  logic           irq_wrap;
  logic           wdt_wrap;

  // free-running grid, never cleared by release
  ftt_tick_divider #(.MOD(IRQ_TICKS)) u_irq_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .clr_i (1'b0),
    .cnt_o (irq_cnt),
    .wrap_o(irq_wrap)
  );

  ftt_irq_latch u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .boundary_i(irq_wrap),
    .release_i (irq_release_i),
    .irq_no    (irq_no)
  );

  ftt_wdt #(.PERIOD(WDT_TICKS), .LOW_W(WDT_LOW)) u_wdt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .kick_i(wdt_kick_i),
    .wrap_o(wdt_wrap),
    .wdt_no(wdt_no)
  );
endmodule

// File: rtl/ftt_checker.sv
module ftt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic irq_release_i,
  input logic wdt_kick_i,
  input logic irq_no,
  input logic wdt_no,
  input logic irq_wrap,
  input logic wdt_wrap
);
  AST_IRQ_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_wrap |=> !irq_no); // R2

  AST_IRQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_release_i && !irq_wrap) |=> irq_no); // R3

  AST_IRQ_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !irq_release_i) |=> $stable(irq_no)); // R5

  AST_WDT_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wdt_kick_i) |=> $stable(wdt_no)); // R5

  AST_WDT_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_wrap && !wdt_kick_i) |=> !wdt_no); // R6

  AST_WDT_KICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_kick_i |=> wdt_no); // R8

  AST_WDT_KICK_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_kick_i |-> !wdt_wrap); // R8
endmodule

bind frame_tick_timers ftt_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .irq_release_i(irq_release_i),
  .wdt_kick_i   (wdt_kick_i),
  .irq_no       (irq_no),
  .wdt_no       (wdt_no),
  .irq_wrap     (irq_wrap),
  .wdt_wrap     (wdt_wrap)
);

// File: tb/sim_frame_tick_timers.sv
module sim_frame_tick_timers;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rel = 1'b0;
  logic kick = 1'b0;
  logic irq_n, wdt_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_tick_timers u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_i       (tick),
    .irq_release_i(rel),
    .wdt_kick_i   (kick),
    .irq_no       (irq_n),
    .wdt_no       (wdt_n)
  );

  // {release first, tick count, expected irq_no}
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 16'd63, 1'b1},  // R2 one short of boundary
    {1'b0, 16'd1,  1'b0},  // R2 boundary at 64
    {1'b0, 16'd10, 1'b0},  // stays low
    {1'b1, 16'd0,  1'b1},  // R3 release
    {1'b0, 16'd53, 1'b1},  // R4 grid not restarted
    {1'b0, 16'd1,  1'b0},  // R4 spacing 64
    {1'b0, 16'd70, 1'b0},  // R4 boundary 192 absorbed
    {1'b1, 16'd0,  1'b1},  // R3 late release
    {1'b0, 16'd57, 1'b1},  // R4 no refire
    {1'b0, 16'd1,  1'b0}   // R4 spacing 128
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_release();
    @(negedge clk) rel = 1'b1;
    @(negedge clk) rel = 1'b0;
  endtask

  task automatic do_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    idle(3);
    check("R1 irq in reset", irq_n, 1'b1);
    check("R1 wdt in reset", wdt_n, 1'b1);
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    idle(2);
    check("R1 irq reset", irq_n, 1'b1);
    check("R1 wdt reset", wdt_n, 1'b1);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < 10; v++) begin
      if (VEC[v][17]) do_release();
      run_ticks(int'(VEC[v][16:1]));
      check($sformatf("R2/R3/R4 vector %0d", v), irq_n, VEC[v][0]);
    end

    // R5: no ticks, irq frozen one tick before a boundary (256 ticks so far)
    do_release();
    run_ticks(63);
    idle(500);
    check("R5 irq holds without ticks", irq_n, 1'b1);
    run_ticks(1);
    check("R2 boundary after idle", irq_n, 1'b0);

    // R9: release and boundary in same cycle
    do_release();
    check("R3 release", irq_n, 1'b1);
    run_ticks(63);
    @(negedge clk) begin tick = 1'b1; rel = 1'b1; end
    @(negedge clk) begin tick = 1'b0; rel = 1'b0; end
    check("R9 boundary beats release", irq_n, 1'b0);

    // watchdog from a fresh reset
    do_reset();
    run_ticks(3999);
    check("R7 no pulse before 4000", wdt_n, 1'b1);
    run_ticks(1);
    check("R7 first pulse at 4000", wdt_n, 1'b0);
    run_ticks(31);
    check("R6 still low at 31", wdt_n, 1'b0);
    run_ticks(1);
    check("R6 high after 32", wdt_n, 1'b1);
    run_ticks(3967);
    check("R6 high before period", wdt_n, 1'b1);
    run_ticks(1);
    check("R6 repeat at 4000", wdt_n, 1'b0);
    run_ticks(5);
    do_kick();
    check("R8 kick ends pulse", wdt_n, 1'b1);
    run_ticks(3999);
    check("R8 reload no early pulse", wdt_n, 1'b1);
    run_ticks(1);
    check("R8 pulse 4000 after kick", wdt_n, 1'b0);
    idle(300);
    check("R5 wdt holds without ticks", wdt_n, 1'b0);

    // R8: kick and tick same cycle
    @(negedge clk) begin tick = 1'b1; kick = 1'b1; end
    @(negedge clk) begin tick = 1'b0; kick = 1'b0; end
    run_ticks(3999);
    check("R8 kick beats tick", wdt_n, 1'b1);
    run_ticks(1);
    check("R8 kick beats tick pulse", wdt_n, 1'b0);

    // R1: reset mid-pulse
    do_reset();
    check("R1 wdt after reset", wdt_n, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < MAX_CYCLES; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule